// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A port and a B port of 18 bits each, split into two 9-bit halves. Each half can be turned around on its own, so the block serves either as one wide transceiver or as two narrow ones, and the two halves may point in opposite directions at once. Every port is modelled as three vectors (input, output and per-bit output enable), which keeps the design free of tri-state logic; the pad ring merges them into real bidirectional pins.

Each direction owns a storage register loaded from its source port on the rising edge of its own capture clock, and a select that picks either live source data or the stored word. This gives transparent, registered, store-only and isolate modes. Loading happens whatever the enables and direction are, so a word can be parked while the buses are isolated and driven out later.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The data path is HALF_W*HALVES bits (default 18); half h covers bits [h*HALF_W +: HALF_W] and is governed by oe_ni[h] and dir_i[h] alone.
- R2: While oe_ni[h] is 1, every a_oe_o and b_oe_o bit of half h is 0.
- R3: While rst_ni is 1 and oe_ni[h] is 0, dir_i[h]=1 sets all b_oe_o bits of half h and clears its a_oe_o bits; dir_i[h]=0 does the reverse.
- R4: The A-to-B register loads a_i on every rising edge of clk_ab_i and the B-to-A register loads b_i on every rising edge of clk_ba_i while rst_ni is 1, regardless of oe_ni and dir_i.
- R5: With sel_ab_i=0 (transparent), b_o equals the live a_i.
- R6: With sel_ab_i=1 (registered), b_o equals the A-to-B register contents.
- R7: The B-to-A direction mirrors R5 and R6: sel_ba_i=0 gives a_o equal to live b_i, sel_ba_i=1 gives a_o equal to the B-to-A register.
- R8: rst_ni=0 clears both registers asynchronously and holds all of a_oe_o and b_oe_o at 0.
- R9: No bit ever has a_oe_o and b_oe_o set together.
- R10: The two halves operate independently, so one half can drive B while the other drives A in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_ab_i | input | 1 | Capture clock of the A-to-B register |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register |
| oe_ni | input | HALVES | Active-low output enable, one per half |
| dir_i | input | HALVES | Direction per half, 1 drives B from A |
| sel_ab_i | input | 1 | B-side source: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | A-side source: 0 live B, 1 stored B |
| a_i | input | HALF_W*HALVES | Data received on the A port |
| a_o | output | HALF_W*HALVES | Data offered to the A port |
| a_oe_o | output | HALF_W*HALVES | Per-bit drive enable of the A port |
| b_i | input | HALF_W*HALVES | Data received on the B port |
| b_o | output | HALF_W*HALVES | Data offered to the B port |
| b_oe_o | output | HALF_W*HALVES | Per-bit drive enable of the B port |

## Verification
The bench builds the block with its defaults, two halves of 9 bits, which is the smallest arrangement where split operation exists: all sixteen combinations of the two enables and two directions can be swept, including halves facing opposite ways. Data patterns differ between halves so a swapped half or a crossed bit range shows up, and captures are issued while isolated, while facing the other way and during reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_src_sel.sv
module xcvr_src_sel
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] y_o
);
  src_e src;
  assign src = src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_STORED: y_o = stored_i;
      default:    y_o = live_i;
    endcase
  end
endmodule

// File: rtl/xcvr_half_ctl.sv
module xcvr_half_ctl #(
  parameter int HW = 9
) (
  input  logic          rst_ni,
  input  logic          oe_ni,
  input  logic          dir_i,
  output logic [HW-1:0] a_oe_o,
  output logic [HW-1:0] b_oe_o
);
  logic on;
  assign on     = rst_ni & ~oe_ni;
  // only one side of a half is ever enabled
  assign b_oe_o = {HW{on & dir_i}};
  assign a_oe_o = {HW{on & ~dir_i}};
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int HALF_W = 9,
  parameter int HALVES = 2,
  localparam int W     = HALF_W * HALVES
) (
  input  logic              rst_ni,
  input  logic              clk_ab_i,
  input  logic              clk_ba_i,
  input  logic [HALVES-1:0] oe_ni,
  input  logic [HALVES-1:0] dir_i,
  input  logic              sel_ab_i,
  input  logic              sel_ba_i,
  input  logic [W-1:0]      a_i,
  output logic [W-1:0]      a_o,
  output logic [W-1:0]      a_oe_o,
  input  logic [W-1:0]      b_i,
  output logic [W-1:0]      b_o,
  output logic [W-1:0]      b_oe_o
);
  logic [W-1:0] ab_q, ba_q;

  xcvr_store #(.W(W)) u_ab_store (
    .clk_i(clk_ab_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(ab_q)
  );
  xcvr_store #(.W(W)) u_ba_store (
    .clk_i(clk_ba_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(ba_q)
  );

  xcvr_src_sel #(.W(W)) u_ab_sel (
    .sel_i(sel_ab_i), .live_i(a_i), .stored_i(ab_q), .y_o(b_o)
  );
  xcvr_src_sel #(.W(W)) u_ba_sel (
    .sel_i(sel_ba_i), .live_i(b_i), .stored_i(ba_q), .y_o(a_o)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xcvr_half_ctl #(.HW(HALF_W)) u_ctl (
      .rst_ni (rst_ni),
      .oe_ni  (oe_ni[h]),
      .dir_i  (dir_i[h]),
      .a_oe_o (a_oe_o[h*HALF_W +: HALF_W]),
      .b_oe_o (b_oe_o[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int HALF_W = 9,
  parameter int HALVES = 2,
  localparam int W     = HALF_W * HALVES
) (
  input logic              rst_ni,
  input logic              clk_ab_i,
  input logic              clk_ba_i,
  input logic [HALVES-1:0] oe_ni,
  input logic [HALVES-1:0] dir_i,
  input logic              sel_ab_i,
  input logic              sel_ba_i,
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      a_o,
  input logic [W-1:0]      a_oe_o,
  input logic [W-1:0]      b_i,
  input logic [W-1:0]      b_o,
  input logic [W-1:0]      b_oe_o
);
  logic seen_ab, seen_ba;
  always_ff @(posedge clk_ab_i or negedge rst_ni)
    if (!rst_ni) seen_ab <= 1'b0; else seen_ab <= 1'b1;
  always_ff @(posedge clk_ba_i or negedge rst_ni)
    if (!rst_ni) seen_ba <= 1'b0; else seen_ba <= 1'b1;

  always_comb begin
    if (rst_ni == 1'b0)
      assert_reset_idle_R8: assert (a_oe_o == '0 && b_oe_o == '0);
  end

  assert_no_contention_R9: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (a_oe_o & b_oe_o) == '0);
  assert_no_contention_ba_R9: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (a_oe_o & b_oe_o) == '0);

  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    localparam int L = h * HALF_W;
    assert_isolate_R2: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
      oe_ni[h] |-> (a_oe_o[L +: HALF_W] == '0 && b_oe_o[L +: HALF_W] == '0));
    assert_dir_R3: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
      (!oe_ni[h] && dir_i[h]) |-> (&b_oe_o[L +: HALF_W] && a_oe_o[L +: HALF_W] == '0));
    assert_dir_ba_R3: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
      (!oe_ni[h] && !dir_i[h]) |-> (&a_oe_o[L +: HALF_W] && b_oe_o[L +: HALF_W] == '0));
  end

  assert_transparent_R5: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !sel_ab_i |-> b_o == a_i);
  assert_registered_R6: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (seen_ab && sel_ab_i) |-> b_o == $past(a_i));
  assert_transparent_R7: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !sel_ba_i |-> a_o == b_i);
  assert_registered_R7: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (seen_ba && sel_ba_i) |-> a_o == $past(b_i));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (.*);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int HW = 9;
  localparam int NH = 2;
  localparam int W  = HW * NH;

  typedef struct {
    logic [W-1:0] a_oe, a_d, b_oe, b_d;
    string        req;
  } item_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, en_ab, en_ba, clk_ab, clk_ba;
  logic [NH-1:0] oe_n, dir;
  logic          sel_ab, sel_ba;
  logic [W-1:0]  a_in, b_in, a_o, a_oe, b_o, b_oe;
  logic [W-1:0]  m_ab, m_ba;

  assign clk_ab = clk & en_ab;
  assign clk_ba = clk & en_ba;

  bus_xcvr_reg #(.HALF_W(HW), .HALVES(NH)) u0 (
    .rst_ni(rst_n), .clk_ab_i(clk_ab), .clk_ba_i(clk_ba),
    .oe_ni(oe_n), .dir_i(dir), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .a_o(a_o), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_o), .b_oe_o(b_oe)
  );

  int    nchk = 0, nerr = 0;
  bit    done = 1'b0;
  item_t q[$];
  event  chk_ev;

  // monitor: pop expected items and compare with the ports
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      nchk++;
      if (a_oe !== it.a_oe || b_oe !== it.b_oe ||
          (a_o & it.a_oe) !== (it.a_d & it.a_oe) ||
          (b_o & it.b_oe) !== (it.b_d & it.b_oe)) begin
        nerr++;
        $display("FAIL %s: actual a_oe=%h a=%h b_oe=%h b=%h expected a_oe=%h a=%h b_oe=%h b=%h",
                 it.req, a_oe, a_o & a_oe, b_oe, b_o & b_oe,
                 it.a_oe, it.a_d & it.a_oe, it.b_oe, it.b_d & it.b_oe);
      end
    end
  end

  // driver: compute expectation from the requirements and push it
  task automatic step(input string req);
    item_t it;
    #1;
    it.a_oe = '0; it.b_oe = '0;
    for (int h = 0; h < NH; h++)
      if (rst_n && !oe_n[h]) begin
        if (dir[h]) it.b_oe[h*HW +: HW] = '1;
        else        it.a_oe[h*HW +: HW] = '1;
      end
    it.b_d = sel_ab ? m_ab : a_in;
    it.a_d = sel_ba ? m_ba : b_in;
    it.req = req;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic pulse_ab();
    @(negedge clk); en_ab = 1'b1;
    if (rst_n) m_ab = a_in;
    @(negedge clk); en_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk); en_ba = 1'b1;
    if (rst_n) m_ba = b_in;
    @(negedge clk); en_ba = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; m_ab = '0; m_ba = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    en_ab = 0; en_ba = 0; oe_n = '0; dir = '1; sel_ab = 1; sel_ba = 1;
    a_in = 18'h2a5c3; b_in = 18'h15a3c;
    do_reset();
    step("R8");
    pulse_ab(); pulse_ba();          // ignored while in reset
    step("R8");
    @(negedge clk); rst_n = 1'b1;
    step("R8");                      // stored words are zero
    dir = '0; step("R8");

    // transparent A to B
    dir = '1; sel_ab = 0; a_in = 18'h3ffff; step("R5");
    a_in = 18'h00001; step("R5");
    a_in = 18'h1e0f3; step("R3");

    // registered A to B
    a_in = 18'h12345; pulse_ab();
    @(negedge clk); a_in = 18'h0abcd; sel_ab = 1; step("R6");
    // capture while isolated
    oe_n = '1; a_in = 18'h2f00f; pulse_ab(); step("R2");
    @(negedge clk); oe_n = '0; a_in = 18'h00ff0; step("R4");
    // capture while facing the other way
    dir = '0; a_in = 18'h31313; pulse_ab();
    @(negedge clk); dir = '1; a_in = '0; step("R4");

    // B to A mirror
    dir = '0; sel_ba = 0; b_in = 18'h2468a; step("R7");
    b_in = 18'h1357b; pulse_ba();
    @(negedge clk); b_in = 18'h3c3c3; sel_ba = 1; step("R7");
    dir = '1; b_in = 18'h0f0f0; pulse_ba();
    @(negedge clk); dir = '0; b_in = '0; step("R4");

    // split halves
    sel_ab = 0; sel_ba = 0; a_in = 18'h3aa55; b_in = 18'h055aa;
    dir = 2'b01; step("R10");
    dir = 2'b10; step("R10");
    oe_n = 2'b01; step("R1");
    oe_n = 2'b10; dir = 2'b01; step("R1");

    // all enable/direction combinations
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      oe_n = k[1:0]; dir = k[3:2];
      a_in = 18'h0b6d1 ^ (k * 18'h01357); b_in = 18'h3c96a ^ (k * 18'h02461);
      step("R9");
    end

    // reset mid-run clears stored words
    oe_n = '0; dir = '1; sel_ab = 1; sel_ba = 1;
    a_in = 18'h1ffff; pulse_ab();
    @(negedge clk); do_reset(); step("R8");
    @(negedge clk); rst_n = 1'b1; step("R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule